// File: doc/BRIEF.md
# Timer Channel Status Flags

This block is the status register of one channel of a 16-bit timer. It keeps three sticky flags: one for a counter wrap (upward past the top, or downward past zero), and one each for the two general registers. A general-register flag records either a compare hit or a capture, depending on how that register is configured. Each flag drives a level interrupt request, masked by its own enable bit.

Software reaches the flags over a simple select/write/data bus. A flag can be cleared only in two steps. First, a read must return that flag as 1, which arms it. Then a write of 0 to the flag's bit clears it. A hardware acknowledge from a DMA transfer can also clear the register-A flag, on channels that have that path.

The channel number is a parameter. It decides whether downward wraps can reach the wrap flag: this is possible on channels 2 to 4, which have up/down counting modes. It also decides whether the DMA clear path exists: channels 0 to 3 have it.

Top module: `tmr_flag_unit`

## Requirements
- R1: After reset, `flags_o`, `irq_o` and `bus_rdata_o` are all zero.
- R2: A pulse on `cnt_wrap_up_i` sets the wrap flag (bit 2) one clock edge later.
- R3: A pulse on `cnt_wrap_dn_i` sets the wrap flag only when the channel has the up/down path (channel 2, 3 or 4) and `updown_mode_i` is 1. Otherwise it leaves the flag unchanged.
- R4: Flag bit 0 belongs to register A and bit 1 to register B. Each is selected by the matching bit of `gr_capture_i`. When that bit is 0 (compare), `cmp_eq_i` sets the flag and `cap_evt_i` is ignored. When it is 1 (capture), `cap_evt_i` sets the flag and `cmp_eq_i` is ignored.
- R5: A write with a 0 in a flag's bit clears that flag when an earlier read returned the flag as 1 and no write has come between them. Any write consumes the armed state.
- R6: A write of 1 to a flag's bit has no effect. A write of 0 has no effect when the last read saw the flag as 0, or when no read came after the previous write. Without a write or a DMA clear, a set flag stays set.
- R7: When a set event and a clear arrive in the same cycle, the flag is 1 afterwards.
- R8: On channels 0 to 3, a pulse on `dma_ack_i` clears flag A with no read needed. On channel 4, the pulse has no effect.
- R9: `irq_o[k]` equals `flags_o[k]` AND `irq_en_i[k]` for each flag.
- R10: During a read (`bus_sel_i`=1, `bus_wr_i`=0), `bus_rdata_o` holds the flags in bits 2:0 and 0 in every higher bit. At all other times it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_wrap_up_i | input | 1 | Counter wrapped from all-ones to zero |
| cnt_wrap_dn_i | input | 1 | Counter wrapped from zero to all-ones |
| updown_mode_i | input | 1 | Channel runs an up/down counting mode |
| gr_capture_i | input | 2 | Per general register: 1 = capture, 0 = compare |
| cmp_eq_i | input | 2 | Per register: counter equals register |
| cap_evt_i | input | 2 | Per register: capture copied the counter |
| dma_ack_i | input | 1 | DMA transfer from register-A request done |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_wdata_i | input | 3 | Write data, one bit per flag |
| bus_rdata_o | output | DATA_W | Read data |
| irq_en_i | input | 3 | Per-flag interrupt enable |
| irq_o | output | 3 | Per-flag level interrupt request |
| flags_o | output | 3 | Current flag values |

## Verification
A wrong arm bit is not visible at the ports until the next write. At that write, a flag either survives a legitimate clear, or it vanishes although the last read saw it at 0. The bench therefore follows every read with a write and checks the flag one edge later. A wrong set-path selection shows up one edge after the event, as a flag that is set or left clear against the compare/capture choice. The parameter-dependent paths are checked by running a channel-2 instance and a channel-4 instance side by side.

// File: rtl/tmr_flag_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the timer status-flag block.
// Assumes flag bit k (k < NUM_GR) belongs to general register k and the
// wrap flag sits just above them.
package tmr_flag_pkg;
    localparam int NUM_GR   = 2;
    localparam int FLAG_N   = NUM_GR + 1;
    localparam int IDX_GRA  = 0;
    localparam int IDX_GRB  = 1;
    localparam int IDX_WRAP = NUM_GR;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2
    } bus_op_e;
endpackage

// File: rtl/tmr_flag_src.sv
`timescale 1ns/1ps
// Module: tmr_flag_src
// Turns raw counter and register events into one set strobe per flag.
// Assumes all inputs are single-cycle strobes that are synchronous to clk.
// HAS_UNDERFLOW selects whether downward wraps can reach the wrap flag.
module tmr_flag_src
    import tmr_flag_pkg::*;
#(
    parameter bit HAS_UNDERFLOW = 1'b1
) (
    input  logic              cnt_wrap_up_i,
    input  logic              cnt_wrap_dn_i,
    input  logic              updown_mode_i,
    input  logic [NUM_GR-1:0] gr_capture_i,
    input  logic [NUM_GR-1:0] cmp_eq_i,
    input  logic [NUM_GR-1:0] cap_evt_i,
    output logic [FLAG_N-1:0] set_o
);
    logic dn_ok;

    // Downward wraps are qualified by the up/down mode, when the path exists.
    generate
        if (HAS_UNDERFLOW) begin : g_dn
            always_comb dn_ok = cnt_wrap_dn_i && updown_mode_i;
        end else begin : g_no_dn
            always_comb dn_ok = 1'b0;
        end
    endgenerate

    // Each general register picks its set source from its compare/capture role.
    generate
        for (genvar g = 0; g < NUM_GR; g++) begin : g_gr
            always_comb set_o[g] = gr_capture_i[g] ? cap_evt_i[g] : cmp_eq_i[g];
        end
    endgenerate

    // Wrap flag: set by any upward wrap or a qualified downward wrap.
    always_comb set_o[IDX_WRAP] = cnt_wrap_up_i || dn_ok;
endmodule

// File: rtl/tmr_flag_bus.sv
`timescale 1ns/1ps
// Module: tmr_flag_bus
// Decodes the register bus into read and write strobes and drives read data.
// Assumes one access per cycle; the read data is valid only while reading.
module tmr_flag_bus
    import tmr_flag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [FLAG_N-1:0] flags_i,
    output logic              rd_stb_o,
    output logic              wr_stb_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int PAD_W = DATA_W - FLAG_N;

    bus_op_e op;

    // Classify this cycle's access.
    always_comb begin
        if (!bus_sel_i)    op = BUS_IDLE;
        else if (bus_wr_i) op = BUS_WRITE;
        else               op = BUS_READ;
    end

    // Strobes and zero-extended read data follow the access type.
    always_comb begin
        rd_stb_o = 1'b0;
        wr_stb_o = 1'b0;
        rdata_o  = '0;
        case (op)
            BUS_READ: begin
                rd_stb_o = 1'b1;
                rdata_o  = {{PAD_W{1'b0}}, flags_i};
            end
            BUS_WRITE: wr_stb_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/tmr_flag_cell.sv
`timescale 1ns/1ps
// Module: tmr_flag_cell
// One sticky status flag. It has a read-armed bit, so that only a read
// which saw the flag at 1, followed by a write of 0, clears it.
// An optional hardware clear needs no arming.
// Assumes rd_i and wr_i are never high together.
module tmr_flag_cell #(
    parameter bit HAS_HW_CLR = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    input  logic hw_clr_i,
    output logic flag_o
);
    logic flag_q;
    logic arm_q;
    logic sw_clr;
    logic hw_clr;

    // Clear requests from software (armed write of 0) and from hardware.
    always_comb begin
        sw_clr = wr_i && !wbit_i && arm_q;
        hw_clr = HAS_HW_CLR && hw_clr_i;
    end

    // Flag register: a set has priority over any clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag_q <= 1'b0;
        else if (set_i)             flag_q <= 1'b1;
        else if (sw_clr || hw_clr)  flag_q <= 1'b0;
    end

    // Arm register: a read loads the flag value seen, and a write or hardware clear disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)                arm_q <= 1'b0;
        else if (wr_i || hw_clr)   arm_q <= 1'b0;
        else if (rd_i)             arm_q <= flag_q;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/tmr_flag_unit.sv
`timescale 1ns/1ps
// Module: tmr_flag_unit (top)
// Status register of one timer channel. It holds the wrap flag and the two
// general-register flags, gives bus access with read-then-clear, and drives
// masked level interrupts.
// CHAN_ID selects the underflow path (channels 2 to 4) and the DMA clear of
// flag A (channels 0 to 3).
module tmr_flag_unit
    import tmr_flag_pkg::*;
#(
    parameter int CHAN_ID = 2,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_wrap_up_i,
    input  logic              cnt_wrap_dn_i,
    input  logic              updown_mode_i,
    input  logic [NUM_GR-1:0] gr_capture_i,
    input  logic [NUM_GR-1:0] cmp_eq_i,
    input  logic [NUM_GR-1:0] cap_evt_i,
    input  logic              dma_ack_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [FLAG_N-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [FLAG_N-1:0] irq_en_i,
    output logic [FLAG_N-1:0] irq_o,
    output logic [FLAG_N-1:0] flags_o
);
    localparam bit HAS_UNDERFLOW = (CHAN_ID >= 2) && (CHAN_ID <= 4);
    localparam bit HAS_DMA_CLR   = (CHAN_ID >= 0) && (CHAN_ID <= 3);

    logic [FLAG_N-1:0] set_vec;
    logic              rd_stb;
    logic              wr_stb;

    tmr_flag_src #(
        .HAS_UNDERFLOW (HAS_UNDERFLOW)
    ) src_i (
        .cnt_wrap_up_i (cnt_wrap_up_i),
        .cnt_wrap_dn_i (cnt_wrap_dn_i),
        .updown_mode_i (updown_mode_i),
        .gr_capture_i  (gr_capture_i),
        .cmp_eq_i      (cmp_eq_i),
        .cap_evt_i     (cap_evt_i),
        .set_o         (set_vec)
    );

    tmr_flag_bus #(
        .DATA_W (DATA_W)
    ) bus_i (
        .bus_sel_i (bus_sel_i),
        .bus_wr_i  (bus_wr_i),
        .flags_i   (flags_o),
        .rd_stb_o  (rd_stb),
        .wr_stb_o  (wr_stb),
        .rdata_o   (bus_rdata_o)
    );

    // One flag cell per status bit; only flag A gets the hardware clear.
    generate
        for (genvar k = 0; k < FLAG_N; k++) begin : g_flag
            tmr_flag_cell #(
                .HAS_HW_CLR ((k == IDX_GRA) && HAS_DMA_CLR)
            ) cell_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_i    (set_vec[k]),
                .rd_i     (rd_stb),
                .wr_i     (wr_stb),
                .wbit_i   (bus_wdata_i[k]),
                .hw_clr_i (dma_ack_i),
                .flag_o   (flags_o[k])
            );
        end
    endgenerate

    // Level interrupt per flag, gated by its enable.
    always_comb irq_o = flags_o & irq_en_i;
endmodule

// File: rtl/tmr_flag_chk.sv
`timescale 1ns/1ps
// Module: tmr_flag_chk
// Assertion checker for tmr_flag_unit, attached with bind below.
// It only observes the top-level ports.
module tmr_flag_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_wrap_up_i,
    input logic              cnt_wrap_dn_i,
    input logic              updown_mode_i,
    input logic [1:0]        gr_capture_i,
    input logic [1:0]        cmp_eq_i,
    input logic              dma_ack_i,
    input logic              bus_sel_i,
    input logic              bus_wr_i,
    input logic [2:0]        bus_wdata_i,
    input logic [DATA_W-1:0] bus_rdata_o,
    input logic [2:0]        flags_o
);
    AST_WRAP_UP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wrap_up_i |=> flags_o[2]); // R2

    AST_DN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags_o[2] && cnt_wrap_dn_i && !updown_mode_i && !cnt_wrap_up_i) |=> !flags_o[2]); // R3

    AST_WRAP_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags_o[2]) |-> $past(bus_sel_i && bus_wr_i && !bus_wdata_i[2])); // R5

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[1] && !(bus_sel_i && bus_wr_i)) |=> flags_o[1]); // R6

    AST_SET_WINS_GRA: assert property (@(posedge clk) disable iff (!rst_n)
        (!gr_capture_i[0] && cmp_eq_i[0]) |=> flags_o[0]); // R7

    AST_GRA_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags_o[0]) |-> $past((bus_sel_i && bus_wr_i && !bus_wdata_i[0]) || dma_ack_i)); // R8

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel_i |-> (bus_rdata_o == '0)); // R10
endmodule

bind tmr_flag_unit tmr_flag_chk #(.DATA_W(DATA_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cnt_wrap_up_i (cnt_wrap_up_i),
    .cnt_wrap_dn_i (cnt_wrap_dn_i),
    .updown_mode_i (updown_mode_i),
    .gr_capture_i  (gr_capture_i),
    .cmp_eq_i      (cmp_eq_i),
    .dma_ack_i     (dma_ack_i),
    .bus_sel_i     (bus_sel_i),
    .bus_wr_i      (bus_wr_i),
    .bus_wdata_i   (bus_wdata_i),
    .bus_rdata_o   (bus_rdata_o),
    .flags_o       (flags_o)
);

// File: tb/tmr_flag_unit_tb_top.sv
`timescale 1ns/1ps
// Bench for tmr_flag_unit. A vector table first, then directed tests.
// Inputs change at the falling edge, and outputs are sampled at the falling edge.
module tmr_flag_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       up, dn, ud, dma, sel, wr;
    logic [1:0] gcap, eq, cev;
    logic [2:0] wdat, ien;
    logic [7:0] rdata, rdata_c4;
    logic [2:0] irq, irq_c4, flags, flags_c4;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    tmr_flag_unit #(.CHAN_ID(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_wrap_up_i(up), .cnt_wrap_dn_i(dn),
        .updown_mode_i(ud), .gr_capture_i(gcap), .cmp_eq_i(eq), .cap_evt_i(cev),
        .dma_ack_i(dma), .bus_sel_i(sel), .bus_wr_i(wr), .bus_wdata_i(wdat),
        .bus_rdata_o(rdata), .irq_en_i(ien), .irq_o(irq), .flags_o(flags));

    tmr_flag_unit #(.CHAN_ID(4)) dut_c4 (
        .clk(clk), .rst_n(rst_n), .cnt_wrap_up_i(up), .cnt_wrap_dn_i(dn),
        .updown_mode_i(ud), .gr_capture_i(gcap), .cmp_eq_i(eq), .cap_evt_i(cev),
        .dma_ack_i(dma), .bus_sel_i(sel), .bus_wr_i(wr), .bus_wdata_i(wdat),
        .bus_rdata_o(rdata_c4), .irq_en_i(ien), .irq_o(irq_c4), .flags_o(flags_c4));

    // Vector layout: [11] up wrap, [10] down wrap, [9] up/down mode,
    // [8:7] capture select, [6:5] compare equal, [4:3] capture event, [2:0] expected flags
    localparam logic [11:0] VEC [10] = '{
        12'b1_0_0_00_00_00_100,
        12'b0_1_1_00_00_00_100,
        12'b0_1_0_00_00_00_000,
        12'b0_0_0_00_01_00_001,
        12'b0_0_0_00_10_00_010,
        12'b0_0_0_00_00_11_000,
        12'b0_0_0_11_00_01_001,
        12'b0_0_0_11_11_00_000,
        12'b0_0_0_10_01_10_011,
        12'b1_1_0_00_11_00_111
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        up = 0; dn = 0; ud = 0; dma = 0; sel = 0; wr = 0;
        gcap = 2'b00; eq = 2'b00; cev = 2'b00; wdat = 3'b000;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic pulse_eq_a();
        eq = 2'b01;
        @(negedge clk);
        eq = 2'b00;
    endtask

    task automatic bus_read();
        sel = 1; wr = 0;
        @(negedge clk);
        sel = 0;
    endtask

    task automatic bus_write(input logic [2:0] d);
        sel = 1; wr = 1; wdat = d;
        @(negedge clk);
        sel = 0; wr = 0; wdat = 3'b000;
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        ien = 3'b111;
        idle();
        rst_n = 0;
        @(negedge clk);
        do_reset();

        // R1: reset state
        chk("R1 flags", {5'd0, flags}, 8'h00);
        chk("R1 irq", {5'd0, irq}, 8'h00);
        chk("R1 rdata", rdata, 8'h00);

        // R2 R3 R4: table of single-cycle event patterns
        for (int i = 0; i < 10; i++) begin
            do_reset();
            up = VEC[i][11]; dn = VEC[i][10]; ud = VEC[i][9];
            gcap = VEC[i][8:7]; eq = VEC[i][6:5]; cev = VEC[i][4:3];
            @(negedge clk);
            idle();
            chk($sformatf("R2 R3 R4 vector %0d", i), {5'd0, flags}, {5'd0, VEC[i][2:0]});
        end

        // R10: read data carries flags during a read, zero otherwise
        do_reset();
        up = 1; eq = 2'b11;
        @(negedge clk);
        idle();
        chk("R10 idle rdata", rdata, 8'h00);
        sel = 1; wr = 0;
        #1;
        chk("R10 read rdata", rdata, 8'h07);
        @(negedge clk);
        sel = 0;

        // R9: interrupt masking
        ien = 3'b101;
        #1;
        chk("R9 irq mask 101", {5'd0, irq}, 8'h05);
        ien = 3'b010;
        #1;
        chk("R9 irq mask 010", {5'd0, irq}, 8'h02);
        ien = 3'b111;

        // R6: writing 1 to armed flags leaves them set
        bus_write(3'b111);
        chk("R6 write ones", {5'd0, flags}, 8'h07);

        // R5: read arms, then write 0 to A only clears A
        bus_read();
        bus_write(3'b110);
        chk("R5 armed clear A", {5'd0, flags}, 8'h06);

        // R5: arm consumed by the write; a second write 0 without a read keeps B and wrap
        bus_write(3'b000);
        chk("R5 arm consumed", {5'd0, flags}, 8'h06);

        // R6: no read since the last write, so a write of 0 is ignored
        pulse_eq_a();
        bus_write(3'b000);
        chk("R6 unarmed write", {5'd0, flags}, 8'h07);

        // R6: a read that saw A at 0 does not arm it
        do_reset();
        bus_read();
        pulse_eq_a();
        bus_write(3'b000);
        chk("R6 read saw zero", {5'd0, flags}, 8'h01);

        // R7: set and armed clear in the same cycle leaves the flag set
        bus_read();
        sel = 1; wr = 1; wdat = 3'b000; eq = 2'b01;
        @(negedge clk);
        idle();
        chk("R7 set wins", {5'd0, flags}, 8'h01);

        // R8: DMA acknowledge clears A on channel 2, not on channel 4
        do_reset();
        pulse_eq_a();
        dma = 1;
        @(negedge clk);
        dma = 0;
        chk("R8 dma clear ch2", {5'd0, flags}, 8'h00);
        chk("R8 dma ignored ch4", {5'd0, flags_c4}, 8'h01);

        // R3: down wrap on channel 4 in up/down mode sets the wrap flag
        do_reset();
        dn = 1; ud = 1;
        @(negedge clk);
        idle();
        chk("R3 down wrap ch4", {5'd0, flags_c4}, 8'h04);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule